// File: doc/BRIEF.md
# Switch Guessing Game with Pseudo-Random Secret

This block runs a number guessing game without any processor. A free-running linear feedback shift register supplies the secret value. The player sets a guess on an 8-bit switch bus. On every cycle the block compares the guess with the secret and drives an 8-bit LED bus with a hint. The low half of the LEDs means the guess is too small. The high half means it is too large.

When the guess equals the secret, the block enters a celebration phase. All LEDs flash together for a fixed number of half periods, and the switches are ignored during this phase. The block then spends one cycle drawing a new secret from the generator and resumes play. The generator advances on every clock cycle. The next secret therefore depends on how long the player took in the previous round.

The block has no debouncing and no display logic. The switch bus is assumed to be synchronised and stable already.

Top module: `guess_game_top`

## Requirements
- R1: While the synchronous reset `rst` is high, `led` is 0x00 and the generator is loaded with `SEED`. The first cycle after reset is a draw cycle, so the first secret equals `SEED`.
- R2: The generator is an 8-bit left-shifting register. Each cycle the XOR of bits 7, 5, 4 and 3 enters bit 0, which gives the polynomial x^8+x^6+x^5+x^4+1. It advances on every non-reset cycle in every state and never holds zero.
- R3: During play, if `sw` is below the secret (unsigned), `led` is 0x0F at the clock edge that samples that switch value.
- R4: During play, if `sw` is above the secret (unsigned), `led` is 0xF0 at the clock edge that samples that switch value.
- R5: When `sw` equals the secret during play, the celebration phase starts with `led` at 0xFF. `led` then alternates between 0xFF and 0x00 every 2^`HALF_LOG2` cycles, for `BLINK_HALVES` half periods in total.
- R6: During the celebration phase, changes of `sw` (including a value equal to the secret) have no effect on `led` or on how long the phase lasts.
- R7: After the last half period there is exactly one draw cycle with `led` at 0x00. The new secret is the generator value during that cycle. Hints resume at the following clock edge.
- R8: The secret changes only in a draw cycle and stays constant for the whole of a round.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sw | input | W | Player's guess from the switches |
| led | output | W | Hint / celebration pattern, registered |

## Verification
On every cycle, the embedded assertions check the following:
- The generator is never zero, and it shifts correctly.
- The secret stays constant outside draw cycles.
- A draw cycle always leads to play.
- During celebration the LEDs show only all-on or all-off, and they change only at half-period boundaries.
- The half-period counter stays within its bound.

Only the bench's scenarios can show the rest:
- The hint values over a complete sweep of switch values against several successive secrets.
- The exact length and phase of the flashing, and that switch activity during it is ignored.
- Which generator value becomes the next secret, predicted by an independent shift-register model.
- The return to `SEED` after a reset in the middle of a round.

// File: rtl/gg_pkg.sv
package gg_pkg;
   typedef enum logic [1:0] {
      GG_DRAW = 2'd0,
      GG_PLAY = 2'd1,
      GG_WIN  = 2'd2
   } gg_state_e;
endpackage

// File: rtl/gg_lfsr.sv
module gg_lfsr #(
   parameter int           W    = 8,
   parameter logic [W-1:0] TAPS = 8'hB8,
   parameter logic [W-1:0] SEED = 8'h5A
) (
   input  logic         clk,
   input  logic         rst,
   output logic [W-1:0] value_o
);
   logic [W-1:0] s_q;
   logic         fb;

   if (SEED == '0) begin : g_bad_seed
      $error("gg_lfsr: SEED must be non-zero");
   end
   if (TAPS[W-1] != 1'b1) begin : g_bad_taps
      $error("gg_lfsr: top tap must be set");
   end

   assign fb = ^(s_q & TAPS);

   always_ff @(posedge clk) begin
      if (rst) s_q <= SEED;
      else     s_q <= {s_q[W-2:0], fb};
   end

   assign value_o = s_q;

   a_r2_nonzero: assert property (@(posedge clk) disable iff (rst) s_q != '0);
   a_r2_shift:   assert property (@(posedge clk) disable iff (rst)
                    1'b1 |=> s_q[W-1:1] == $past(s_q[W-2:0]));
endmodule

// File: rtl/gg_hint.sv
module gg_hint #(
   parameter int W = 8
) (
   input  logic [W-1:0] guess_i,
   input  logic [W-1:0] secret_i,
   output logic         eq_o,
   output logic [W-1:0] pattern_o
);
   localparam int HALF = W / 2;

   logic lt, gt;

   assign lt   = guess_i < secret_i;
   assign gt   = guess_i > secret_i;
   assign eq_o = guess_i == secret_i;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i < HALF) begin : g_lo
         assign pattern_o[i] = lt;
      end else begin : g_hi
         assign pattern_o[i] = gt;
      end
   end
endmodule

// File: rtl/gg_blink.sv
module gg_blink #(
   parameter int HALF_LOG2    = 3,
   parameter int BLINK_HALVES = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic start_i,
   input  logic run_i,
   output logic half_done_o,
   output logic last_half_o
);
   localparam int HW = $clog2(BLINK_HALVES + 1);

   logic [HALF_LOG2-1:0] cnt_q;
   logic [HW-1:0]        halves_q;

   if (HALF_LOG2 < 1) begin : g_bad_half
      $error("gg_blink: HALF_LOG2 must be at least 1");
   end
   if (BLINK_HALVES < 1) begin : g_bad_halves
      $error("gg_blink: BLINK_HALVES must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst || start_i) begin
         cnt_q    <= '0;
         halves_q <= '0;
      end else if (run_i) begin
         cnt_q <= cnt_q + 1'b1;
         if (cnt_q == '1) halves_q <= halves_q + 1'b1;
      end
   end

   assign half_done_o = run_i && (cnt_q == '1);
   assign last_half_o = halves_q == HW'(BLINK_HALVES - 1);

   a_r5_halves_bound: assert property (@(posedge clk) disable iff (rst)
                         run_i |-> halves_q < HW'(BLINK_HALVES));
endmodule

// File: rtl/guess_game_top.sv
module guess_game_top #(
   parameter int           W            = 8,
   parameter logic [W-1:0] TAPS         = 8'hB8,
   parameter logic [W-1:0] SEED         = 8'h5A,
   parameter int           HALF_LOG2    = 3,
   parameter int           BLINK_HALVES = 6
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] sw,
   output logic [W-1:0] led
);
   import gg_pkg::*;

   gg_state_e    st_q;
   logic [W-1:0] secret_q;
   logic [W-1:0] led_q;
   logic [W-1:0] rnd;
   logic [W-1:0] pattern;
   logic         eq;
   logic         half_done;
   logic         last_half;
   logic         win_start;

   if (W < 4 || (W % 2) != 0) begin : g_bad_width
      $error("guess_game_top: W must be even and at least 4");
   end

   gg_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) lfsr_i (
      .clk     (clk),
      .rst     (rst),
      .value_o (rnd)
   );

   gg_hint #(.W(W)) hint_i (
      .guess_i   (sw),
      .secret_i  (secret_q),
      .eq_o      (eq),
      .pattern_o (pattern)
   );

   assign win_start = (st_q == GG_PLAY) && eq;

   gg_blink #(.HALF_LOG2(HALF_LOG2), .BLINK_HALVES(BLINK_HALVES)) blink_i (
      .clk         (clk),
      .rst         (rst),
      .start_i     (win_start),
      .run_i       (st_q == GG_WIN),
      .half_done_o (half_done),
      .last_half_o (last_half)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q     <= GG_DRAW;
         secret_q <= '0;
         led_q    <= '0;
      end else begin
         case (st_q)
            GG_DRAW: begin
               secret_q <= rnd;
               led_q    <= '0;
               st_q     <= GG_PLAY;
            end
            GG_PLAY: begin
               if (eq) begin
                  led_q <= '1;
                  st_q  <= GG_WIN;
               end else begin
                  led_q <= pattern;
               end
            end
            GG_WIN: begin
               if (half_done) begin
                  if (last_half) begin
                     led_q <= '0;
                     st_q  <= GG_DRAW;
                  end else begin
                     led_q <= ~led_q;
                  end
               end
            end
            default: begin
               st_q  <= GG_DRAW;
               led_q <= '0;
            end
         endcase
      end
   end

   assign led = led_q;

   a_r7_draw_to_play:  assert property (@(posedge clk) disable iff (rst)
                          st_q == GG_DRAW |=> st_q == GG_PLAY);
   a_r5_win_pattern:   assert property (@(posedge clk) disable iff (rst)
                          st_q == GG_WIN |-> (led_q == '1 || led_q == '0));
   a_r6_hold_in_half:  assert property (@(posedge clk) disable iff (rst)
                          (st_q == GG_WIN && !half_done) |=> $stable(led_q));
   a_r8_secret_held:   assert property (@(posedge clk) disable iff (rst)
                          st_q != GG_DRAW |=> $stable(secret_q));
endmodule

// File: tb/guess_game_top_tb_top.sv
module guess_game_top_tb_top;
   localparam int         CLK_PERIOD = 10;
   localparam int         HLOG       = 2;
   localparam int         HALVES     = 4;
   localparam int         WIN_CYC    = HALVES * (1 << HLOG);
   localparam logic [7:0] SEED_V     = 8'h5A;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] sw  = 8'h00;
   logic [7:0] led;
   logic [7:0] model_q;
   int         checks = 0;
   int         errors = 0;
   bit         done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   guess_game_top #(
      .W(8), .TAPS(8'hB8), .SEED(SEED_V),
      .HALF_LOG2(HLOG), .BLINK_HALVES(HALVES)
   ) dut_i (
      .clk (clk),
      .rst (rst),
      .sw  (sw),
      .led (led)
   );

   // independent generator model, R2: bits 7,5,4,3 XOR into bit 0
   always @(posedge clk) begin
      if (rst) model_q <= SEED_V;
      else     model_q <= {model_q[6:0], model_q[7] ^ model_q[5] ^ model_q[4] ^ model_q[3]};
   end

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s led=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] hint_of(input logic [7:0] g, input logic [7:0] s);
      if (g < s)      return 8'h0F;
      else if (g > s) return 8'hF0;
      else            return 8'hFF;
   endfunction

   // R3, R4, R8: every non-matching guess against a fixed secret
   task automatic sweep(input logic [7:0] sec);
      for (int v = 0; v < 256; v++) begin
         if (v[7:0] != sec) begin
            sw = v[7:0];
            @(negedge clk);
            chk((v[7:0] < sec) ? "R3 below" : "R4 above", led, hint_of(v[7:0], sec));
         end
      end
      // R8: revisit the extremes at the end of the round
      if (sec != 8'h00) begin
         sw = 8'h00;
         @(negedge clk);
         chk("R8 secret held", led, 8'h0F);
      end
   endtask

   // R5, R6, R7: match, flashing, draw, resume
   task automatic win(input logic [7:0] sec, output logic [7:0] nxt);
      sw = sec;
      for (int j = 0; j < WIN_CYC; j++) begin
         @(negedge clk);
         chk((j < 2) ? "R5 flash" : "R6 ignore sw", led,
             (((j >> HLOG) % 2) == 0) ? 8'hFF : 8'h00);
         if (j >= 1) sw = (j % 3 == 0) ? sec : 8'(j * 37 + 5);
      end
      @(negedge clk);
      chk("R7 draw cycle", led, 8'h00);
      nxt = model_q;
      sw  = ~nxt;
      @(negedge clk);
      chk("R7 first play edge", led, 8'h00);
      @(negedge clk);
      chk("R7 hints resume", led, hint_of(~nxt, nxt));
   endtask

   initial begin
      logic [7:0] sec;
      logic [7:0] nxt;
      repeat (3) @(negedge clk);
      chk("R1 led in reset", led, 8'h00);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 draw after reset", led, 8'h00);
      sec = SEED_V;
      for (int r = 0; r < 3; r++) begin
         sweep(sec);
         win(sec, nxt);
         sec = nxt;
      end
      // R1: reset in mid-round returns to the seed
      rst = 1'b1;
      @(negedge clk);
      chk("R1 mid-round reset", led, 8'h00);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 draw after reset", led, 8'h00);
      sw = SEED_V - 8'd1;
      @(negedge clk);
      chk("R1 secret is seed (below)", led, 8'h0F);
      sw = SEED_V + 8'd1;
      @(negedge clk);
      chk("R1 secret is seed (above)", led, 8'hF0);
      win(SEED_V, nxt);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog act=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule